// File: doc/BRIEF.md
# Process-Tagged Write-Back Data Cache

This block is a four-way set-associative write-back data cache placed between a processor load/store port and a simple word-wide external memory port. The total capacity is 8 KB, held as 64 sets of 32-byte lines. Lines are tagged by a modified virtual address, not by a physical one. When a processor access falls in the lowest 32 MB, the top seven address bits are replaced by the current seven-bit process identifier before lookup. Accesses at or above 32 MB keep their address as it is. The modified address is also the address presented on the memory port.

A separate maintenance port offers two operations. The first cleans and invalidates a single line, named by its raw address. The second invalidates every line at once and discards any dirty data. By-address maintenance never inserts the process identifier, so a line filled for a low address under some process is reached only by giving its full modified address.

Only one request is in progress at a time. Misses refill a whole line. A dirty victim, picked round-robin within its set, is first written back word by word. The process identifier is loaded through its own control input. A new value applies to the next accepted request and does not flush the cache.

Top module: `mva_wb_dcache`

## Requirements
- R1: After reset, every line is invalid, `cpu_req_ready` is high, and `cpu_rsp_valid`, `mnt_done` and `mem_valid` are low.
- R2: A load miss issues 8 word reads on the memory port (`mem_write` low), in ascending order from the 32-byte-aligned line base. The load then returns the memory word at the requested offset.
- R3: A load hit returns the cached word with no memory transaction. `cpu_rsp_valid` pulses for one cycle, two clock edges after the accepting edge.
- R4: A store hit updates the cached word and marks the line dirty with no memory transaction. A later load of that address returns the stored value.
- R5: A store miss first refills the line with 8 reads, then applies the store in the cache. No memory write is issued.
- R6: For a processor address whose bits [31:25] are zero, the lookup and memory address use the process identifier in bits [31:25] and the address's own bits [24:0].
- R7: A processor address with any of bits [31:25] set is used unchanged for lookup and memory access.
- R8: A process identifier written through `pid_wr_en`/`pid_wr_data` applies to the next request. Lines filled under an earlier identifier stay resident and hit again once that identifier is restored.
- R9: Line replacement within a set is round-robin over the four ways, in fill order. A line is evicted only when the pointer reaches its way.
- R10: A dirty victim is written back as 8 ascending word writes from its own line base, carrying its current data, before the refill reads start.
- R11: Maintenance op 0 (clean-and-invalidate line) uses `mnt_req_addr` without process identifier insertion. If the line is present and dirty, it writes the 8 words back. Whenever the line is present, the line is then invalid. `mnt_done` pulses for one cycle when the operation completes.
- R12: Maintenance op 1 (invalidate all) clears every line with no memory transaction and discards dirty data.
- R13: While a refill or write-back is active (`mem_valid` high), `cpu_req_ready` and `mnt_req_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Processor request can be accepted |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Processor byte address (virtual) |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse for load or store |
| cpu_rsp_rdata | output | 32 | Load data, valid with `cpu_rsp_valid` |
| mnt_req_valid | input | 1 | Maintenance request valid |
| mnt_req_ready | output | 1 | Maintenance request can be accepted (processor requests take priority) |
| mnt_req_op | input | 1 | 0 = clean-and-invalidate line, 1 = invalidate all |
| mnt_req_addr | input | 32 | Raw address for the line operation |
| mnt_done | output | 1 | One-cycle pulse when a maintenance operation completes |
| pid_wr_en | input | 1 | Load the process identifier |
| pid_wr_data | input | 7 | New process identifier |
| mem_valid | output | 1 | Memory word transaction requested |
| mem_ready | input | 1 | Memory completes the transaction this cycle |
| mem_write | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 32 | Word address (modified virtual address) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, sampled when `mem_valid` and `mem_ready` are both high |

## Verification
A table of loads and stores splits hits from misses by the number of memory transactions each one causes. Store hits and store misses are told apart by whether a refill occurs, and no case may issue a memory write. Low addresses under two process identifiers show that the identifier lands in the top bits and that switching back hits lines filled earlier. Five distinct lines driven into one set, one of them dirty, expose the victim order and the content and order of the write-back. Maintenance runs on dirty, clean and absent lines, and with a raw low address. This separates write-back from plain invalidation and confirms that no identifier is inserted. An invalidate-all after a store shows that the stored data is lost.

// File: rtl/mvac_pkg.sv
package mvac_pkg;

    parameter int ADDR_W     = 32;
    parameter int WORD_W     = 32;
    parameter int NUM_SETS   = 64;
    parameter int NUM_WAYS   = 4;
    parameter int LINE_WORDS = 8;
    parameter int PID_W      = 7;

    localparam int BYTE_W   = $clog2(WORD_W / 8);
    localparam int OFF_W    = $clog2(LINE_WORDS);
    localparam int IDX_W    = $clog2(NUM_SETS);
    localparam int WAY_W    = $clog2(NUM_WAYS);
    localparam int TAG_W    = ADDR_W - IDX_W - OFF_W - BYTE_W;
    localparam int LOW_W    = ADDR_W - PID_W;
    localparam int SLOT_W   = IDX_W + WAY_W + OFF_W;
    localparam int NUM_SLOT = NUM_SETS * NUM_WAYS * LINE_WORDS;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [OFF_W-1:0]  word;
        logic [BYTE_W-1:0] byte_off;
    } mva_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WB,
        ST_FILL,
        ST_MLOOK
    } cstate_t;

    typedef enum logic [2:0] {
        TC_NONE,
        TC_FILL,
        TC_DIRTY,
        TC_INVAL,
        TC_INVALL
    } tcmd_t;

    function automatic logic [ADDR_W-1:0] build_mva(
        input logic [ADDR_W-1:0] addr,
        input logic [PID_W-1:0]  pid,
        input logic              raw
    );
        if (!raw && (addr[ADDR_W-1:LOW_W] == '0))
            return {pid, addr[LOW_W-1:0]};
        return addr;
    endfunction

endpackage

// File: rtl/mvac_addr_map.sv
module mvac_addr_map
    import mvac_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [PID_W-1:0]  pid,
    input  logic              raw,
    output mva_t              mva
);
    always_comb mva = mva_t'(build_mva(addr, pid, raw));
endmodule

// File: rtl/mvac_tag_store.sv
module mvac_tag_store
    import mvac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic              hit_dirty,
    output logic [WAY_W-1:0]  vic_way,
    output logic              vic_valid,
    output logic              vic_dirty,
    output logic [TAG_W-1:0]  vic_tag,
    input  tcmd_t             cmd,
    input  logic [WAY_W-1:0]  cmd_way,
    input  logic [TAG_W-1:0]  cmd_tag
);
    logic [TAG_W-1:0]    tag_q   [NUM_SETS][NUM_WAYS];
    logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
    logic [NUM_WAYS-1:0] dirty_q [NUM_SETS];
    logic [WAY_W-1:0]    rr_q    [NUM_SETS];
    logic [NUM_WAYS-1:0] match;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign match[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < NUM_WAYS; w++)
            if (match[w]) hit_way = WAY_W'(w);
    end

    assign hit       = |match;
    assign hit_dirty = dirty_q[lk_idx][hit_way];
    assign vic_way   = rr_q[lk_idx];
    assign vic_valid = valid_q[lk_idx][vic_way];
    assign vic_dirty = dirty_q[lk_idx][vic_way];
    assign vic_tag   = tag_q[lk_idx][vic_way];

    always_ff @(posedge clk) begin
        if (cmd == TC_FILL) tag_q[lk_idx][cmd_way] <= cmd_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                rr_q[s]    <= '0;
            end
        end else begin
            unique case (cmd)
                TC_FILL: begin
                    valid_q[lk_idx][cmd_way] <= 1'b1;
                    dirty_q[lk_idx][cmd_way] <= 1'b0;
                    rr_q[lk_idx]             <= rr_q[lk_idx] + 1'b1;
                end
                TC_DIRTY: dirty_q[lk_idx][cmd_way] <= 1'b1;
                TC_INVAL: begin
                    valid_q[lk_idx][cmd_way] <= 1'b0;
                    dirty_q[lk_idx][cmd_way] <= 1'b0;
                end
                TC_INVALL: begin
                    for (int s = 0; s < NUM_SETS; s++) begin
                        valid_q[s] <= '0;
                        dirty_q[s] <= '0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mvac_data_store.sv
module mvac_data_store
    import mvac_pkg::*;
(
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [OFF_W-1:0]  rd_word,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [OFF_W-1:0]  wr_word,
    input  logic [WORD_W-1:0] wr_data
);
    logic [WORD_W-1:0] words_q [NUM_SLOT];
    logic [SLOT_W-1:0] rd_slot, wr_slot;

    assign rd_slot = {idx, rd_way, rd_word};
    assign wr_slot = {idx, wr_way, wr_word};
    assign rd_data = words_q[rd_slot];

    always_ff @(posedge clk) begin
        if (wr_en) words_q[wr_slot] <= wr_data;
    end
endmodule

// File: rtl/mva_wb_dcache.sv
module mva_wb_dcache
    import mvac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [WORD_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [WORD_W-1:0] cpu_rsp_rdata,
    input  logic              mnt_req_valid,
    output logic              mnt_req_ready,
    input  logic              mnt_req_op,
    input  logic [ADDR_W-1:0] mnt_req_addr,
    output logic              mnt_done,
    input  logic              pid_wr_en,
    input  logic [PID_W-1:0]  pid_wr_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    cstate_t           state_q;
    mva_t              mva_q, cpu_mva, mnt_mva;
    logic [PID_W-1:0]  pid_q;
    logic              wr_q, is_mnt_q, op_all_q;
    logic [WORD_W-1:0] wdata_q, rsp_data_q;
    logic              rsp_valid_q, done_q;
    logic [OFF_W-1:0]  cnt_q;
    logic [WAY_W-1:0]  vic_way_q;
    logic [TAG_W-1:0]  wb_tag_q;

    logic              hit, hit_dirty, vic_valid, vic_dirty;
    logic [WAY_W-1:0]  hit_way, vic_way;
    logic [TAG_W-1:0]  vic_tag;
    tcmd_t             tcmd;
    logic [WAY_W-1:0]  tcmd_way;
    logic [WAY_W-1:0]  rd_way;
    logic [OFF_W-1:0]  rd_word;
    logic [WORD_W-1:0] rd_data;
    logic              dwe;
    logic [WAY_W-1:0]  dw_way;
    logic [OFF_W-1:0]  dw_word;
    logic [WORD_W-1:0] dw_data;
    logic              cpu_fire, mnt_fire, beat, last_beat;

    mvac_addr_map u_map_cpu (.addr(cpu_req_addr), .pid(pid_q), .raw(1'b0), .mva(cpu_mva));
    mvac_addr_map u_map_mnt (.addr(mnt_req_addr), .pid(pid_q), .raw(1'b1), .mva(mnt_mva));

    mvac_tag_store u_tags (
        .clk, .rst,
        .lk_idx(mva_q.idx), .lk_tag(mva_q.tag),
        .hit, .hit_way, .hit_dirty,
        .vic_way, .vic_valid, .vic_dirty, .vic_tag,
        .cmd(tcmd), .cmd_way(tcmd_way), .cmd_tag(mva_q.tag)
    );

    mvac_data_store u_data (
        .clk, .idx(mva_q.idx),
        .rd_way, .rd_word, .rd_data,
        .wr_en(dwe), .wr_way(dw_way), .wr_word(dw_word), .wr_data(dw_data)
    );

    assign cpu_req_ready = (state_q == ST_IDLE);
    assign mnt_req_ready = (state_q == ST_IDLE) && !cpu_req_valid;
    assign cpu_fire      = cpu_req_valid && cpu_req_ready;
    assign mnt_fire      = mnt_req_valid && mnt_req_ready;
    assign cpu_rsp_valid = rsp_valid_q;
    assign cpu_rsp_rdata = rsp_data_q;
    assign mnt_done      = done_q;

    assign mem_valid = (state_q == ST_WB) || (state_q == ST_FILL);
    assign mem_write = (state_q == ST_WB);
    assign mem_addr  = {(state_q == ST_WB) ? wb_tag_q : mva_q.tag,
                        mva_q.idx, cnt_q, {BYTE_W{1'b0}}};
    assign mem_wdata = rd_data;
    assign beat      = mem_valid && mem_ready;
    assign last_beat = beat && (cnt_q == OFF_W'(LINE_WORDS - 1));

    assign rd_way  = (state_q == ST_WB) ? vic_way_q : hit_way;
    assign rd_word = (state_q == ST_WB) ? cnt_q : mva_q.word;

    always_comb begin
        tcmd     = TC_NONE;
        tcmd_way = vic_way_q;
        dwe      = 1'b0;
        dw_way   = hit_way;
        dw_word  = mva_q.word;
        dw_data  = wdata_q;
        unique case (state_q)
            ST_LOOK: if (hit && wr_q) begin
                dwe      = 1'b1;
                tcmd     = TC_DIRTY;
                tcmd_way = hit_way;
            end
            ST_WB: if (last_beat && is_mnt_q) tcmd = TC_INVAL;
            ST_FILL: if (beat) begin
                dwe     = 1'b1;
                dw_way  = vic_way_q;
                dw_word = cnt_q;
                dw_data = mem_rdata;
                if (last_beat) tcmd = TC_FILL;
            end
            ST_MLOOK: begin
                if (op_all_q) tcmd = TC_INVALL;
                else if (hit && !hit_dirty) begin
                    tcmd     = TC_INVAL;
                    tcmd_way = hit_way;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            pid_q       <= '0;
            mva_q       <= '0;
            wr_q        <= 1'b0;
            is_mnt_q    <= 1'b0;
            op_all_q    <= 1'b0;
            wdata_q     <= '0;
            rsp_data_q  <= '0;
            rsp_valid_q <= 1'b0;
            done_q      <= 1'b0;
            cnt_q       <= '0;
            vic_way_q   <= '0;
            wb_tag_q    <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            done_q      <= 1'b0;
            if (pid_wr_en) pid_q <= pid_wr_data;
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_fire) begin
                        mva_q    <= cpu_mva;
                        wr_q     <= cpu_req_write;
                        wdata_q  <= cpu_req_wdata;
                        is_mnt_q <= 1'b0;
                        state_q  <= ST_LOOK;
                    end else if (mnt_fire) begin
                        mva_q    <= mnt_mva;
                        op_all_q <= mnt_req_op;
                        is_mnt_q <= 1'b1;
                        state_q  <= ST_MLOOK;
                    end
                end
                ST_LOOK: begin
                    if (hit) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= rd_data;
                        state_q     <= ST_IDLE;
                    end else begin
                        vic_way_q <= vic_way;
                        wb_tag_q  <= vic_tag;
                        cnt_q     <= '0;
                        state_q   <= (vic_valid && vic_dirty) ? ST_WB : ST_FILL;
                    end
                end
                ST_WB: begin
                    if (beat) cnt_q <= cnt_q + 1'b1;
                    if (last_beat) begin
                        if (is_mnt_q) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (beat) cnt_q <= cnt_q + 1'b1;
                    if (last_beat) state_q <= ST_LOOK;
                end
                ST_MLOOK: begin
                    if (!op_all_q && hit && hit_dirty) begin
                        vic_way_q <= hit_way;
                        wb_tag_q  <= mva_q.tag;
                        cnt_q     <= '0;
                        state_q   <= ST_WB;
                    end else begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mvac_checker.sv
module mvac_checker
    import mvac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_rsp_valid,
    input logic              mnt_req_valid,
    input logic              mnt_req_ready,
    input logic              mnt_req_op,
    input logic              mnt_done,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr
);
    AST_BUSY_DURING_MEM: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (!cpu_req_ready && !mnt_req_ready)); // R13

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && cpu_req_ready) |=> (!cpu_req_ready && !mnt_req_ready)); // R13

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_rsp_valid |=> !cpu_rsp_valid); // R3

    AST_NO_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && cpu_req_ready) |=> !cpu_rsp_valid); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        mnt_done |=> !mnt_done); // R11

    AST_INVALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mnt_req_valid && mnt_req_ready && mnt_req_op) |=> !mem_valid); // R12

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[BYTE_W-1:0] == '0)); // R2

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> $stable(mem_addr)); // R10
endmodule

bind mva_wb_dcache mvac_checker chk_i (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_rsp_valid(cpu_rsp_valid),
    .mnt_req_valid(mnt_req_valid), .mnt_req_ready(mnt_req_ready),
    .mnt_req_op(mnt_req_op), .mnt_done(mnt_done),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr)
);

// File: tb/mva_wb_dcache_tb_top.sv
module mva_wb_dcache_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
    logic        cpu_req_ready, cpu_rsp_valid;
    logic [31:0] cpu_rsp_rdata;
    logic        mnt_req_valid = 1'b0, mnt_req_op = 1'b0;
    logic [31:0] mnt_req_addr = '0;
    logic        mnt_req_ready, mnt_done;
    logic        pid_wr_en = 1'b0;
    logic [6:0]  pid_wr_data = '0;
    logic        mem_valid, mem_ready, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mva_wb_dcache dut_i (.*);

    // memory model: written words kept, others derived from the address
    bit [31:0] bmem [bit [31:0]];
    logic [31:0] log_addr [32];
    logic [31:0] log_data [32];
    logic        log_wr   [32];
    int          log_n = 0;
    bit          overlap = 0;

    function automatic logic [31:0] mfun(input logic [31:0] a);
        return a ^ 32'h5A5A_A5A5;
    endfunction

    assign mem_ready = mem_valid;

    always @(negedge clk)
        mem_rdata = bmem.exists(mem_addr) ? bmem[mem_addr] : mfun(mem_addr);

    always @(posedge clk) begin
        if (!rst && mem_valid && (cpu_req_ready || mnt_req_ready)) overlap = 1;
        if (!rst && mem_valid && mem_ready) begin
            if (log_n < 32) begin
                log_addr[log_n] = mem_addr;
                log_data[log_n] = mem_wdata;
                log_wr[log_n]   = mem_write;
            end
            log_n++;
            if (mem_write) bmem[mem_addr] = mem_wdata;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output int ops);
        int guard;
        @(negedge clk);
        while (!cpu_req_ready) @(negedge clk);
        log_n = 0;
        cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = addr; cpu_req_wdata = wd;
        @(negedge clk);
        cpu_req_valid = 0;
        guard = 0;
        while (!cpu_rsp_valid && guard < 200) begin @(negedge clk); guard++; end
        rd  = cpu_rsp_rdata;
        ops = log_n;
    endtask

    task automatic mnt_op(input logic op, input logic [31:0] addr, output int ops, output logic seen);
        int guard;
        @(negedge clk);
        while (!mnt_req_ready) @(negedge clk);
        log_n = 0;
        mnt_req_valid = 1; mnt_req_op = op; mnt_req_addr = addr;
        @(negedge clk);
        mnt_req_valid = 0;
        guard = 0;
        while (!mnt_done && guard < 200) begin @(negedge clk); guard++; end
        seen = mnt_done;
        ops  = log_n;
    endtask

    task automatic set_pid(input logic [6:0] p);
        @(negedge clk);
        pid_wr_en = 1; pid_wr_data = p;
        @(negedge clk);
        pid_wr_en = 0;
    endtask

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [7:0]  ops;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h4000_0004, 32'h0,         8'd8, 4'd2}, // R2 load miss
        '{1'b0, 32'h4000_0008, 32'h0,         8'd0, 4'd3}, // R3 load hit
        '{1'b1, 32'h4000_0010, 32'h1111_1111, 8'd0, 4'd4}, // R4 store hit
        '{1'b0, 32'h4000_0010, 32'h0,         8'd0, 4'd4}, // R4 read back
        '{1'b1, 32'h4000_1020, 32'h2222_2222, 8'd8, 4'd5}, // R5 store miss
        '{1'b0, 32'h4000_1020, 32'h0,         8'd0, 4'd5}, // R5 read back
        '{1'b0, 32'h8000_0000, 32'h0,         8'd8, 4'd7}  // R7 high address
    };

    function automatic string rname(input logic [3:0] r);
        case (r)
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int ops;
        logic seen;
        bit [31:0] shadow [bit [31:0]];

        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        check("R1 ready", {31'b0, cpu_req_ready}, 32'd1);
        check("R1 rsp", {31'b0, cpu_rsp_valid}, 32'd0);
        check("R1 mem", {31'b0, mem_valid}, 32'd0);
        check("R1 done", {31'b0, mnt_done}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] exp;
            cpu_op(VECS[i].wr, VECS[i].addr, VECS[i].wdata, rd, ops);
            check({rname(VECS[i].req), " ops"}, ops, {24'b0, VECS[i].ops});
            if (VECS[i].wr) shadow[VECS[i].addr] = VECS[i].wdata;
            else begin
                exp = shadow.exists(VECS[i].addr) ? shadow[VECS[i].addr] : mfun(VECS[i].addr);
                check({rname(VECS[i].req), " data"}, rd, exp);
            end
            for (int k = 0; k < 32; k++)
                if (k < ops && log_wr[k]) check({rname(VECS[i].req), " no write"}, 32'd1, 32'd0);
        end

        // R2 refill order
        cpu_op(0, 32'h4000_2008, 0, rd, ops);
        check("R2 ops", ops, 8);
        for (int k = 0; k < 8; k++) begin
            check("R2 addr", log_addr[k], 32'h4000_2000 + 32'(4 * k));
            check("R2 read", {31'b0, log_wr[k]}, 0);
        end
        check("R2 data", rd, mfun(32'h4000_2008));

        // R6 identifier insertion
        set_pid(7'd5);
        cpu_op(0, 32'h0000_0104, 0, rd, ops);
        check("R6 ops", ops, 8);
        check("R6 addr", log_addr[0], 32'h0A00_0100);
        check("R6 data", rd, mfun(32'h0A00_0104));

        // R8 identifier switch keeps lines
        set_pid(7'd9);
        cpu_op(0, 32'h0000_0104, 0, rd, ops);
        check("R8 new pid miss", ops, 8);
        check("R8 new pid addr", log_addr[0], 32'h1200_0100);
        set_pid(7'd5);
        cpu_op(0, 32'h0000_0104, 0, rd, ops);
        check("R8 old pid hit", ops, 0);
        check("R8 old pid data", rd, mfun(32'h0A00_0104));

        // R9 / R10 replacement in set 0
        cpu_op(0, 32'h4000_4000, 0, rd, ops);
        check("R9 fourth way fill", ops, 8);
        cpu_op(0, 32'h4000_6000, 0, rd, ops);
        check("R10 ops", ops, 16);
        for (int k = 0; k < 8; k++) begin
            check("R10 wb addr", log_addr[k], 32'h4000_0000 + 32'(4 * k));
            check("R10 wb write", {31'b0, log_wr[k]}, 1);
        end
        check("R10 wb data", log_data[4], 32'h1111_1111);
        check("R10 fill after", log_addr[8], 32'h4000_6000);
        cpu_op(0, 32'h8000_0000, 0, rd, ops);
        check("R9 second fill kept", ops, 0);
        cpu_op(0, 32'h4000_0010, 0, rd, ops);
        check("R9 evicted line misses", ops, 8);
        check("R10 data reached memory", rd, 32'h1111_1111);

        // R11 clean-and-invalidate
        cpu_op(1, 32'h4000_1024, 32'h3333_3333, rd, ops);
        check("R11 setup hit", ops, 0);
        mnt_op(0, 32'h4000_1020, ops, seen);
        check("R11 done", {31'b0, seen}, 1);
        check("R11 dirty wb ops", ops, 8);
        check("R11 wb addr", log_addr[0], 32'h4000_1020);
        check("R11 wb word0", log_data[0], 32'h2222_2222);
        check("R11 wb word1", log_data[1], 32'h3333_3333);
        cpu_op(0, 32'h4000_1020, 0, rd, ops);
        check("R11 invalidated", ops, 8);
        check("R11 data", rd, 32'h2222_2222);
        mnt_op(0, 32'h4000_1020, ops, seen);
        check("R11 clean no wb", ops, 0);
        cpu_op(0, 32'h4000_1020, 0, rd, ops);
        check("R11 clean invalidated", ops, 8);
        cpu_op(1, 32'h0000_0104, 32'h4444_4444, rd, ops);
        check("R11 low store hit", ops, 0);
        mnt_op(0, 32'h0000_0104, ops, seen);
        check("R11 raw low addr no match", ops, 0);
        mnt_op(0, 32'h0A00_0104, ops, seen);
        check("R11 full mva wb", ops, 8);
        check("R11 full mva addr", log_addr[0], 32'h0A00_0100);
        check("R11 full mva data", log_data[1], 32'h4444_4444);

        // R12 invalidate all discards dirty data
        cpu_op(1, 32'h4000_0010, 32'h5555_5555, rd, ops);
        check("R12 setup hit", ops, 0);
        mnt_op(1, 32'h0, ops, seen);
        check("R12 done", {31'b0, seen}, 1);
        check("R12 no traffic", ops, 0);
        cpu_op(0, 32'h4000_0010, 0, rd, ops);
        check("R12 miss after", ops, 8);
        check("R12 dirty discarded", rd, 32'h1111_1111);

        // R13 busy while memory active
        check("R13 ready low during transfer", {31'b0, overlap}, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule